// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block sits between one channel of an 8-bit timer and the general-purpose port pin that channel shares. It keeps a single compare-output state bit, updates it when the timer reports a compare match or when software strikes the force strobe, and decides whether the pin carries that bit or the ordinary port data bit. The pin's output enable always comes from the port direction bit.

A two-bit action field selects what a compare event does to the state bit. The same field also selects the pin data source. Changes to the field act at once and are never held back to wait for a compare event. A two-bit waveform-mode input tells the block whether the timer runs in a non-PWM mode (normal or clear-on-match) or a PWM mode. The waveform mode changes what a match does and whether a force is accepted. It does not change which source drives the pin.

The usual set-up sequence is to choose the action, strike the force strobe so the state bit holds a known level, and only then set the direction bit so the pin starts driving.

Top module: `ocu_pin_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state bit `oc_state_o` and the match event output `match_flag_o` are both 0 after that edge.
- R2: When `com_i` is not 00, `pin_o` equals `oc_state_o`. When `com_i` is 00, `pin_o` equals `port_data_i`.
- R3: `pin_oe_o` follows `port_dir_i` for every combination of `com_i` and `wgm_i`.
- R4: The choice of pin data source in R2 is the same for all four `wgm_i` values.
- R5: A match with `com_i` = 00 leaves the state bit unchanged, in every waveform mode.
- R6: `com_i` has no buffering. A new value selects the pin source within the same cycle, and it sets the action taken by a match at the very next clock edge.
- R7: A change of `wgm_i` with no match and no accepted force leaves the state bit unchanged.
- R8: With `wgm_i` = 00 (normal) or 01 (clear-on-match), a match at a rising edge updates the state bit at that edge: `com_i` 01 toggles it, 10 clears it, 11 sets it.
- R9: With `wgm_i` = 00 or 01, a high `force_i` applies the R8 action at that edge without any match. If force and match fall in the same cycle, the action is applied only once.
- R10: With `wgm_i` = 10 or 11 (PWM), `force_i` has no effect on the state bit.
- R11: `match_flag_o` is high for exactly the cycle after each edge that samples `match_i` high. A force never raises it.
- R12: With `wgm_i` = 10 or 11, a match with `com_i` 10 clears the state bit, 11 sets it, and 01 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| match_i | input | 1 | Single-cycle compare-match pulse from the timer |
| com_i | input | 2 | Compare action and pin source field |
| force_i | input | 1 | Force-compare strobe |
| wgm_i | input | 2 | Waveform mode: 00 normal, 01 clear-on-match, 10/11 PWM |
| port_data_i | input | 1 | Port data register bit |
| port_dir_i | input | 1 | Port direction bit, 1 = output |
| pin_o | output | 1 | Data presented to the pin driver |
| pin_oe_o | output | 1 | Pin output enable |
| oc_state_o | output | 1 | Compare-output state bit |
| match_flag_o | output | 1 | One-cycle event for each real compare match |

## Verification
The hardest case to reach is a force and a match arriving in the same cycle while the field is set to toggle. Two separate updates would cancel each other and look exactly like no update at all. The bench drives both strobes together in normal mode, starting from a known state, and expects one inversion. It then repeats the pair in PWM mode, where only the match may act. A second hard case is a field write that falls in the same cycle as a match. The stimulus changes `com_i` together with a match pulse and checks that the new action, not the old one, reaches the state bit.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

  localparam int unsigned COM_W = 2;
  localparam int unsigned WGM_W = 2;

  typedef enum logic [COM_W-1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_act_e;

  typedef enum logic [WGM_W-1:0] {
    WG_NORMAL = 2'b00,
    WG_CTC    = 2'b01,
    WG_PWM_F  = 2'b10,
    WG_PWM_P  = 2'b11
  } wg_mode_e;

  function automatic logic is_pwm(input logic [WGM_W-1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/ocu_action_dec.sv
module ocu_action_dec
  import ocu_pkg::*;
(
  input  logic [COM_W-1:0] com_i,
  input  logic [WGM_W-1:0] wgm_i,
  input  logic             match_i,
  input  logic             force_i,
  output oc_act_e          act_o,
  output logic             fire_o
);

  logic pwm;
  logic trig;

  assign pwm = is_pwm(wgm_i);

  // In PWM modes only a real match triggers an update; a force is dropped.
  always_comb begin
    if (pwm) begin
      trig = match_i;
    end else begin
      trig = match_i | force_i;
    end
  end

  always_comb begin
    act_o = ACT_NONE;
    if (pwm) begin
      unique case (com_i)
        2'b10:   act_o = ACT_CLEAR;
        2'b11:   act_o = ACT_SET;
        default: act_o = ACT_NONE;
      endcase
    end else begin
      unique case (com_i)
        2'b01:   act_o = ACT_TOGGLE;
        2'b10:   act_o = ACT_CLEAR;
        2'b11:   act_o = ACT_SET;
        default: act_o = ACT_NONE;
      endcase
    end
  end

  assign fire_o = trig && (act_o != ACT_NONE);

endmodule

// File: rtl/ocu_state_reg.sv
module ocu_state_reg
  import ocu_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  oc_act_e act_i,
  input  logic    fire_i,
  input  logic    match_i,
  input  logic    nop_i,
  output logic    state_o,
  output logic    flag_o
);

  logic state_q;
  logic state_d;
  logic flag_q;
  logic rst_seen_q;

  always_comb begin
    state_d = state_q;
    if (fire_i) begin
      unique case (act_i)
        ACT_TOGGLE: state_d = ~state_q;
        ACT_CLEAR:  state_d = 1'b0;
        ACT_SET:    state_d = 1'b1;
        default:    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= match_i;
    end
    rst_seen_q <= rst;
  end

  assign state_o = state_q;
  assign flag_o  = flag_q;

  always @(negedge clk) begin
    if (rst_seen_q) begin
      AST_RESET_CLEAR: assert (state_q == 1'b0 && flag_q == 1'b0); // R1
    end
  end

  AST_HOLD_ON_NOP: assert property (@(posedge clk) disable iff (rst)
    (nop_i && match_i) |=> $stable(state_q)); // R5

  AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    match_i |=> flag_q); // R11

endmodule

// File: rtl/ocu_pin_mux.sv
module ocu_pin_mux
  import ocu_pkg::*;
(
  input  logic [COM_W-1:0] com_i,
  input  logic             state_i,
  input  logic             port_data_i,
  input  logic             port_dir_i,
  output logic             pin_o,
  output logic             pin_oe_o
);

  logic override;

  // Any set action bit hands the pin data over to the compare state.
  assign override = |com_i;
  assign pin_o    = override ? state_i : port_data_i;
  assign pin_oe_o = port_dir_i;

endmodule

// File: rtl/ocu_pin_unit.sv
module ocu_pin_unit
  import ocu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       match_i,
  input  logic [1:0] com_i,
  input  logic       force_i,
  input  logic [1:0] wgm_i,
  input  logic       port_data_i,
  input  logic       port_dir_i,
  output logic       pin_o,
  output logic       pin_oe_o,
  output logic       oc_state_o,
  output logic       match_flag_o
);

  oc_act_e act;
  logic    fire;
  logic    state;
  logic    flag;
  logic    nop;

  assign nop = (com_i == 2'b00);

  ocu_action_dec u_dec (
    .com_i   (com_i),
    .wgm_i   (wgm_i),
    .match_i (match_i),
    .force_i (force_i),
    .act_o   (act),
    .fire_o  (fire)
  );

  ocu_state_reg u_state (
    .clk     (clk),
    .rst     (rst),
    .act_i   (act),
    .fire_i  (fire),
    .match_i (match_i),
    .nop_i   (nop),
    .state_o (state),
    .flag_o  (flag)
  );

  ocu_pin_mux u_mux (
    .com_i       (com_i),
    .state_i     (state),
    .port_data_i (port_data_i),
    .port_dir_i  (port_dir_i),
    .pin_o       (pin_o),
    .pin_oe_o    (pin_oe_o)
  );

  assign oc_state_o   = state;
  assign match_flag_o = flag;

  AST_FORCE_PWM_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (force_i && wgm_i[1] && !match_i) |=> $stable(oc_state_o)); // R10

  AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (match_i && !wgm_i[1] && com_i == 2'b01) |=> (oc_state_o != $past(oc_state_o))); // R8

  AST_WGM_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!match_i && !force_i && wgm_i != $past(wgm_i)) |=> $stable(oc_state_o)); // R7

  AST_FLAG_NOT_FORCE: assert property (@(posedge clk) disable iff (rst)
    (force_i && !match_i) |=> !match_flag_o); // R11

  AST_PWM_SET: assert property (@(posedge clk) disable iff (rst)
    (match_i && wgm_i[1] && com_i == 2'b11) |=> oc_state_o); // R12

endmodule

// File: tb/ocu_pin_unit_tb.sv
`timescale 1ns/1ps
module ocu_pin_unit_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       match_i;
  logic [1:0] com_i;
  logic       force_i;
  logic [1:0] wgm_i;
  logic       port_data_i;
  logic       port_dir_i;
  logic       pin_o;
  logic       pin_oe_o;
  logic       oc_state_o;
  logic       match_flag_o;

  always #2 clk = ~clk;

  ocu_pin_unit u_dut (
    .clk          (clk),
    .rst          (rst),
    .match_i      (match_i),
    .com_i        (com_i),
    .force_i      (force_i),
    .wgm_i        (wgm_i),
    .port_data_i  (port_data_i),
    .port_dir_i   (port_dir_i),
    .pin_o        (pin_o),
    .pin_oe_o     (pin_oe_o),
    .oc_state_o   (oc_state_o),
    .match_flag_o (match_flag_o)
  );

  typedef struct {
    logic  st;
    logic  pin;
    logic  oe;
    logic  flg;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic m_st = 1'b0;
  bit   done = 1'b0;

  task automatic check1(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input bit r, input bit m, input logic [1:0] c, input bit f,
                      input logic [1:0] w, input bit pd, input bit dir, input string req);
    exp_t e;
    bit   trig;
    @(negedge clk);
    rst = r; match_i = m; com_i = c; force_i = f; wgm_i = w;
    port_data_i = pd; port_dir_i = dir;
    if (r) begin
      m_st = 1'b0;
    end else begin
      trig = w[1] ? m : (m | f);
      if (trig) begin
        if (!w[1]) begin
          case (c)
            2'b01: m_st = ~m_st;
            2'b10: m_st = 1'b0;
            2'b11: m_st = 1'b1;
            default: ;
          endcase
        end else begin
          case (c)
            2'b10: m_st = 1'b0;
            2'b11: m_st = 1'b1;
            default: ;
          endcase
        end
      end
    end
    e.st  = m_st;
    e.pin = (c != 2'b00) ? m_st : pd;
    e.oe  = dir;
    e.flg = r ? 1'b0 : m;
    e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: compares after each rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check1(e.req, "oc_state_o",   oc_state_o,   e.st);
      check1(e.req, "pin_o",        pin_o,        e.pin);
      check1(e.req, "pin_oe_o",     pin_oe_o,     e.oe);
      check1(e.req, "match_flag_o", match_flag_o, e.flg);
    end
  end

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; match_i = 0; com_i = 0; force_i = 0; wgm_i = 0;
    port_data_i = 0; port_dir_i = 0;
    // R1 reset
    step(1, 0, 2'b11, 0, 2'b00, 1, 1, "R1");
    step(1, 1, 2'b11, 1, 2'b00, 1, 1, "R1");
    // R2 pin follows port data with field 00
    step(0, 0, 2'b00, 0, 2'b00, 1, 1, "R2");
    step(0, 0, 2'b00, 0, 2'b00, 0, 1, "R2");
    // R9 force sets state before enabling pin; R3 oe off
    step(0, 0, 2'b11, 1, 2'b00, 0, 0, "R9");
    step(0, 0, 2'b11, 0, 2'b00, 0, 1, "R3");
    // R8 matches in normal and CTC
    step(0, 1, 2'b10, 0, 2'b00, 1, 1, "R8");
    step(0, 1, 2'b01, 0, 2'b01, 0, 1, "R8");
    step(0, 1, 2'b01, 0, 2'b01, 0, 1, "R8");
    step(0, 1, 2'b11, 0, 2'b01, 0, 1, "R8");
    // R5 field 00 match no change, every mode
    for (int w = 0; w < 4; w++) step(0, 1, 2'b00, 0, w[1:0], 0, 1, "R5");
    // R11 flag only one cycle, force does not raise it
    step(0, 0, 2'b11, 0, 2'b00, 0, 1, "R11");
    step(0, 0, 2'b10, 1, 2'b00, 1, 1, "R11");
    // R9 force plus match in toggle mode: single toggle
    step(0, 1, 2'b01, 1, 2'b00, 0, 1, "R9");
    step(0, 1, 2'b01, 1, 2'b01, 0, 1, "R9");
    // R7 mode changes keep state
    step(0, 0, 2'b01, 0, 2'b10, 0, 1, "R7");
    step(0, 0, 2'b01, 0, 2'b11, 0, 1, "R7");
    step(0, 0, 2'b01, 0, 2'b00, 0, 1, "R7");
    // R10 force ignored in PWM
    step(0, 0, 2'b10, 1, 2'b10, 1, 1, "R10");
    step(0, 0, 2'b01, 1, 2'b11, 1, 1, "R10");
    // R12 PWM matches
    step(0, 1, 2'b01, 0, 2'b10, 1, 1, "R12");
    step(0, 1, 2'b10, 1, 2'b11, 1, 1, "R12");
    step(0, 1, 2'b11, 0, 2'b10, 0, 1, "R12");
    step(0, 1, 2'b01, 1, 2'b11, 0, 1, "R12");
    // R6 field change same cycle as match uses new action
    step(0, 1, 2'b10, 0, 2'b00, 1, 1, "R6");
    step(0, 0, 2'b00, 0, 2'b00, 1, 1, "R6");
    step(0, 0, 2'b11, 0, 2'b00, 1, 1, "R6");
    // R4 source choice same in every waveform mode, R3 oe follows dir
    for (int w = 0; w < 4; w++) begin
      step(0, 0, 2'b10, 0, w[1:0], 1, w[0], "R4");
      step(0, 0, 2'b00, 0, w[1:0], 1, !w[0], "R4");
    end
    // R1 reset from state 1
    step(0, 1, 2'b11, 0, 2'b00, 0, 1, "R1");
    step(1, 0, 2'b11, 0, 2'b00, 0, 1, "R1");
    step(0, 0, 2'b00, 0, 2'b00, 0, 0, "R1");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule